// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block collects 32 raw interrupt lines and turns them into a small grid of parent interrupt outputs, one group of four parent lines for each core. Every source is brought into the clock domain through a two-flop synchroniser. It is then judged as a level or as an edge with a chosen polarity, and it is gated by a per-source enable. A per-source routing byte decides which parent line and which core the source reaches.

Software drives the block over a simple 32-bit register bus with byte strobes. Enables are changed only through separate set and clear registers, so two agents can change different enables without a read-modify-write. Edge-mode events are held in a latch until software acknowledges them in the status register or disables the source.

Top module: `routed_intc`

## Requirements
- R1: After reset every enable is 0, every polarity bit is 1, every edge-select bit is 0, every routing byte is 0x00, and all parent outputs and the status register read 0.
- R2: Byte offset n in 0x00..0x1F holds the routing byte of source n, on lane n mod 4 of the word at offset n rounded down to a multiple of 4. A write updates only the lanes whose byte strobe is 1, and the written value reads back.
- R3: Offset 0x24 reads the enable mask. Each 1 written to 0x28 sets that enable and each 1 written to 0x2C clears it. Bits written as 0 leave their enables unchanged, and 0x28 and 0x2C read as 0.
- R4: With edge-select bit 0 (offset 0x34), a source is level sensitive: active while its input is 1 when its polarity bit (offset 0x30) is 1, and while it is 0 when that bit is 0. Status bit n (offset 0x40) is 1 while source n is active and enabled.
- R5: With edge-select bit 1, a rising input edge (polarity 1) or a falling input edge (polarity 0) on an enabled source sets a latch. The latch keeps the status bit at 1 after the input returns. Writing 1 to that status bit clears it, and writing 0 there has no effect.
- R6: Clearing the enable of an edge-mode source also discards its latched event, so re-enabling the source shows status 0 until a new edge arrives.
- R7: After all ones are written to offset 0x2C, the status register reads 0 until some source is enabled again.
- R8: Parent output bit c*4+i (core c, line i) is the registered OR, over all sources, of status AND routing bit 4+i AND routing bit c. A source whose routing byte is 0x00 drives no output.
- R9: A level input change reaches the parent output on the third rising clock edge after it is applied, and an edge-mode event on the fourth. Read data is valid after the clock edge that samples the read.
- R10: Reads of unmapped or unaligned offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_be | input | 4 | Byte strobes for the write data lanes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_src | input | 32 | Raw asynchronous interrupt inputs |
| parent_irq | output | 16 | Parent interrupt lines, bit core*4+line |

## Verification
A level input takes three clock edges to reach a parent output: two synchroniser edges and the output register. An edge-mode event adds one edge for its latch. The bench drives inputs on a falling edge and samples exactly on the falling edges after the second, third and fourth rising edges, so a result that comes one cycle early or late is caught. Register effects land on the edge that samples the write, and read data appears after the edge that samples the read. The bench samples read data on the falling edge that follows. Where no exact cycle is under test, it waits several cycles past the longest path before it compares.

// File: rtl/ric_pkg.sv
package ric_pkg;

  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned LANES  = BUS_W / 8;

  localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_SET    = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_POL    = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_TRIG   = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h40;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ROUTE,
    SEL_ENABLE,
    SEL_SET,
    SEL_CLR,
    SEL_POL,
    SEL_TRIG,
    SEL_STATUS
  } reg_sel_e;

  // Map a byte address to a register; unaligned addresses map nowhere.
  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a,
                                          input int unsigned route_bytes);
    reg_sel_e s;
    s = SEL_NONE;
    if (a[1:0] == 2'b00) begin
      if (32'(a) < route_bytes) s = SEL_ROUTE;
      else begin
        case (a)
          OFS_ENABLE: s = SEL_ENABLE;
          OFS_SET:    s = SEL_SET;
          OFS_CLR:    s = SEL_CLR;
          OFS_POL:    s = SEL_POL;
          OFS_TRIG:   s = SEL_TRIG;
          OFS_STATUS: s = SEL_STATUS;
          default:    s = SEL_NONE;
        endcase
      end
    end
    return s;
  endfunction

  // Expand byte strobes into a bit mask.
  function automatic logic [BUS_W-1:0] lane_mask(input logic [LANES-1:0] be);
    logic [BUS_W-1:0] m;
    for (int b = 0; b < LANES; b++) m[8*b +: 8] = {8{be[b]}};
    return m;
  endfunction

  // Byte-strobed merge of new data into an old word.
  function automatic logic [BUS_W-1:0] lane_merge(input logic [BUS_W-1:0] old_w,
                                                  input logic [BUS_W-1:0] new_w,
                                                  input logic [LANES-1:0] be);
    logic [BUS_W-1:0] m;
    m = lane_mask(be);
    return (old_w & ~m) | (new_w & m);
  endfunction

  // Level evaluation: active when the synchronised input equals polarity.
  function automatic logic level_active(input logic in_s, input logic pol);
    return ~(in_s ^ pol);
  endfunction

  // Edge evaluation: rising when polarity is 1, falling when it is 0.
  function automatic logic edge_seen(input logic cur, input logic prev,
                                     input logic pol);
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction

  // One routing byte: upper nibble picks the line, lower nibble the core.
  function automatic logic route_hit(input logic [7:0] rb, input int line,
                                     input int core);
    return rb[4 + line] & rb[core];
  endfunction

endpackage

// File: rtl/ric_sync_trig.sv
module ric_sync_trig #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic [NUM_SRC-1:0] pol,
  input  logic [NUM_SRC-1:0] trig_edge,
  input  logic [NUM_SRC-1:0] en,
  input  logic [NUM_SRC-1:0] ack_mask,
  input  logic [NUM_SRC-1:0] dis_mask,
  output logic [NUM_SRC-1:0] status,
  output logic [NUM_SRC-1:0] evt
);
  import ric_pkg::*;

  logic [NUM_SRC-1:0] sync1_q, sync2_q, prev_q, latch_q, latch_d, lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      sync1_q <= irq_src;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      latch_q <= latch_d;
    end
  end

  always_comb begin
    for (int n = 0; n < NUM_SRC; n++) begin
      lvl[n] = level_active(sync2_q[n], pol[n]);
      evt[n] = trig_edge[n] & edge_seen(sync2_q[n], prev_q[n], pol[n]);
    end
    // A new event beats an acknowledge in the same cycle; a disable beats both.
    latch_d = trig_edge & ~dis_mask & ((latch_q & ~ack_mask) | (evt & en));
    status  = en & ((trig_edge & latch_q) | (~trig_edge & lvl));
  end

  // R5
  latch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((latch_q & ~$past(latch_q)) & ~$past(evt & en)) == '0);

  // R6
  dis_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dis_mask) |=> ((latch_q & $past(dis_mask)) == '0));

endmodule

// File: rtl/ric_regfile.sv
module ric_regfile #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ric_pkg::ADDR_W-1:0]  bus_addr,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ric_pkg::LANES-1:0]   bus_be,
  input  logic [ric_pkg::BUS_W-1:0]   bus_wdata,
  output logic [ric_pkg::BUS_W-1:0]   bus_rdata,
  input  logic [NUM_SRC-1:0]          status,
  output logic [NUM_SRC-1:0]          en,
  output logic [NUM_SRC-1:0]          pol,
  output logic [NUM_SRC-1:0]          trig_edge,
  output logic [NUM_SRC*8-1:0]        route_flat,
  output logic [NUM_SRC-1:0]          ack_mask,
  output logic [NUM_SRC-1:0]          dis_mask
);
  import ric_pkg::*;

  localparam int unsigned ROUTE_WORDS = (NUM_SRC + LANES - 1) / LANES;
  localparam int unsigned ROUTE_BYTES = ROUTE_WORDS * LANES;
  localparam int unsigned RW_IDX_W    = (ROUTE_WORDS > 1) ? $clog2(ROUTE_WORDS) : 1;

  logic [BUS_W-1:0]    route_q [ROUTE_WORDS];
  logic [NUM_SRC-1:0]  en_q, pol_q, trig_q;
  reg_sel_e            sel;
  logic [BUS_W-1:0]    wbits, rd_val;
  logic [NUM_SRC-1:0]  wbits_src;
  logic [RW_IDX_W-1:0] widx;

  assign sel       = decode_ofs(bus_addr, ROUTE_BYTES);
  assign wbits     = bus_wdata & lane_mask(bus_be);
  assign wbits_src = wbits[NUM_SRC-1:0];
  assign widx      = bus_addr[2 +: RW_IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '1;
      trig_q <= '0;
      for (int w = 0; w < ROUTE_WORDS; w++) route_q[w] <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_ROUTE: route_q[widx] <= lane_merge(route_q[widx], bus_wdata, bus_be);
        SEL_SET:   en_q   <= en_q | wbits_src;
        SEL_CLR:   en_q   <= en_q & ~wbits_src;
        SEL_POL:   pol_q  <= lane_merge(BUS_W'(pol_q), bus_wdata, bus_be)
                             ;
        SEL_TRIG:  trig_q <= lane_merge(BUS_W'(trig_q), bus_wdata, bus_be)
                             ;
        default:   ;
      endcase
    end
  end

  assign ack_mask = (bus_wr && sel == SEL_STATUS) ? wbits_src : '0;
  assign dis_mask = (bus_wr && sel == SEL_CLR)    ? wbits_src : '0;

  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_ROUTE:  rd_val = route_q[widx];
      SEL_ENABLE: rd_val[NUM_SRC-1:0] = en_q;
      SEL_POL:    rd_val[NUM_SRC-1:0] = pol_q;
      SEL_TRIG:   rd_val[NUM_SRC-1:0] = trig_q;
      SEL_STATUS: rd_val[NUM_SRC-1:0] = status;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= bus_rd ? rd_val : '0;
  end

  assign en        = en_q;
  assign pol       = pol_q;
  assign trig_edge = trig_q;

  always_comb begin
    for (int n = 0; n < NUM_SRC; n++)
      route_flat[n*8 +: 8] = route_q[n / LANES][8*(n % LANES) +: 8];
  end

  // R3
  set_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_SET) |=> ((en_q & $past(wbits_src)) == $past(wbits_src)));

  // R3
  clr_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_CLR) |=> ((en_q & $past(wbits_src)) == '0));

  // R10
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel == SEL_NONE) |=> (bus_rdata == '0));

  // R10
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_NONE) |=> ($stable(en_q) && $stable(pol_q) && $stable(trig_q)));

endmodule

// File: rtl/ric_route_or.sv
module ric_route_or #(
  parameter int unsigned NUM_SRC    = 32,
  parameter int unsigned NUM_PARENT = 4,
  parameter int unsigned NUM_CORE   = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC-1:0]             status,
  input  logic [NUM_SRC*8-1:0]           route_flat,
  output logic [NUM_CORE*NUM_PARENT-1:0] parent_irq
);
  import ric_pkg::*;

  localparam int unsigned NUM_OUT = NUM_CORE * NUM_PARENT;

  logic [NUM_OUT-1:0] any_hit;

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    for (genvar i = 0; i < NUM_PARENT; i++) begin : g_line
      logic [NUM_SRC-1:0] hit;
      always_comb begin
        for (int n = 0; n < NUM_SRC; n++)
          hit[n] = status[n] & route_hit(route_flat[n*8 +: 8], i, c);
      end
      assign any_hit[c*NUM_PARENT + i] = |hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) parent_irq <= '0;
    else        parent_irq <= any_hit;
  end

  // R8
  parent_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|parent_irq) |-> $past(|status));

endmodule

// File: rtl/routed_intc.sv
module routed_intc #(
  parameter int unsigned NUM_SRC    = 32,
  parameter int unsigned NUM_PARENT = 4,
  parameter int unsigned NUM_CORE   = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ric_pkg::ADDR_W-1:0]     bus_addr,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [ric_pkg::LANES-1:0]      bus_be,
  input  logic [ric_pkg::BUS_W-1:0]      bus_wdata,
  output logic [ric_pkg::BUS_W-1:0]      bus_rdata,
  input  logic [NUM_SRC-1:0]             irq_src,
  output logic [NUM_CORE*NUM_PARENT-1:0] parent_irq
);
  import ric_pkg::*;

  localparam int unsigned ROUTE_BYTES = ((NUM_SRC + LANES - 1) / LANES) * LANES;

  logic [NUM_SRC-1:0]   en, pol, trig_edge, ack_mask, dis_mask, status, evt;
  logic [NUM_SRC*8-1:0] route_flat;

  ric_regfile #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .status(status), .en(en), .pol(pol), .trig_edge(trig_edge),
    .route_flat(route_flat), .ack_mask(ack_mask), .dis_mask(dis_mask)
  );

  ric_sync_trig #(.NUM_SRC(NUM_SRC)) u_front (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
    .pol(pol), .trig_edge(trig_edge), .en(en),
    .ack_mask(ack_mask), .dis_mask(dis_mask),
    .status(status), .evt(evt)
  );

  ric_route_or #(.NUM_SRC(NUM_SRC), .NUM_PARENT(NUM_PARENT), .NUM_CORE(NUM_CORE)) u_route (
    .clk(clk), .rst_n(rst_n), .status(status),
    .route_flat(route_flat), .parent_irq(parent_irq)
  );

  // R7
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && decode_ofs(bus_addr, ROUTE_BYTES) == SEL_CLR &&
     (bus_wdata & lane_mask(bus_be)) == '1) |=> (status == '0));

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> (parent_irq == '0 || $past(|status)));

endmodule

// File: tb/routed_intc_tb.sv
module routed_intc_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] irq_src;
  logic [15:0] parent_irq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  routed_intc u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_src(irq_src), .parent_irq(parent_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_src = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_be = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(8'h24, d); chk("R1 enable", d, 32'h0);
    rd(8'h30, d); chk("R1 polarity", d, 32'hFFFF_FFFF);
    rd(8'h34, d); chk("R1 edge", d, 32'h0);
    rd(8'h1C, d); chk("R1 route", d, 32'h0);
    rd(8'h40, d); chk("R1 status", d, 32'h0);
    chk("R1 parents", {16'h0, parent_irq}, 32'h0);
  endtask

  task automatic t_route();
    logic [31:0] d;
    do_reset();
    wr(8'h04, 32'hAABB_CCDD, 4'b0101);
    rd(8'h04, d); chk("R2 strobed lanes", d, 32'h00BB_00DD);
    wr(8'h04, 32'h1122_3344, 4'b1000);
    rd(8'h04, d); chk("R2 single lane", d, 32'h11BB_00DD);
    wr(8'h1C, 32'h8421_1248, 4'b1111);
    rd(8'h1C, d); chk("R2 full word", d, 32'h8421_1248);
    rd(8'h00, d); chk("R2 other word", d, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    do_reset();
    wr(8'h28, 32'h0000_00F0, 4'hF);
    rd(8'h24, d); chk("R3 set", d, 32'h0000_00F0);
    wr(8'h28, 32'h0000_000F, 4'hF);
    rd(8'h24, d); chk("R3 set keeps", d, 32'h0000_00FF);
    wr(8'h2C, 32'h0000_0030, 4'hF);
    rd(8'h24, d); chk("R3 clear", d, 32'h0000_00CF);
    wr(8'h28, 32'hFFFF_0000, 4'b0100);
    rd(8'h24, d); chk("R3 strobed set", d, 32'h00FF_00CF);
    rd(8'h28, d); chk("R3 set reads zero", d, 32'h0);
    rd(8'h2C, d); chk("R3 clear reads zero", d, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    do_reset();
    // source 5 -> line 2 (bit 6), core 1 (bit 1): byte 0x42, output bit 6
    wr(8'h04, 32'h0000_4200, 4'b0010);
    wr(8'h28, 32'h0000_0020, 4'hF);
    irq_src[5] = 1'b1;
    @(negedge clk); chk("R9 level edge1", {16'h0, parent_irq}, 32'h0);
    @(negedge clk); chk("R9 level edge2", {16'h0, parent_irq}, 32'h0);
    @(negedge clk); chk("R9 level edge3", {16'h0, parent_irq}, 32'h0040);
    rd(8'h40, d); chk("R4 active high status", d, 32'h0000_0020);
    irq_src[5] = 1'b0;
    idle(5);
    rd(8'h40, d); chk("R4 high inactive", d, 32'h0);
    chk("R4 parent drops", {16'h0, parent_irq}, 32'h0);
    wr(8'h30, ~32'h0000_0020, 4'hF);
    idle(2);
    rd(8'h40, d); chk("R4 active low status", d, 32'h0000_0020);
    irq_src[5] = 1'b1;
    idle(5);
    rd(8'h40, d); chk("R4 low inactive", d, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    do_reset();
    // source 9 -> line 0 core 0: byte 0x11 in word 0x08 lane 1, output bit 0
    wr(8'h08, 32'h0000_1100, 4'b0010);
    wr(8'h34, 32'h0000_0200, 4'hF);
    wr(8'h28, 32'h0000_0200, 4'hF);
    irq_src[9] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); chk("R9 edge edge3", {16'h0, parent_irq}, 32'h0);
    @(negedge clk); chk("R9 edge edge4", {16'h0, parent_irq}, 32'h0001);
    irq_src[9] = 1'b0;
    idle(5);
    rd(8'h40, d); chk("R5 rising held", d, 32'h0000_0200);
    wr(8'h40, 32'h0000_0000, 4'hF);
    rd(8'h40, d); chk("R5 zero ack ignored", d, 32'h0000_0200);
    wr(8'h40, 32'h0000_0200, 4'hF);
    rd(8'h40, d); chk("R5 ack clears", d, 32'h0);
    idle(1);
    chk("R5 parent after ack", {16'h0, parent_irq}, 32'h0);
    wr(8'h30, ~32'h0000_0200, 4'hF);
    irq_src[9] = 1'b1;
    idle(5);
    rd(8'h40, d); chk("R5 rise ignored when falling", d, 32'h0);
    irq_src[9] = 1'b0;
    idle(5);
    rd(8'h40, d); chk("R5 falling latched", d, 32'h0000_0200);
    wr(8'h2C, 32'h0000_0200, 4'hF);
    wr(8'h28, 32'h0000_0200, 4'hF);
    idle(2);
    rd(8'h40, d); chk("R6 disable drops latch", d, 32'h0);
    chk("R6 parent quiet", {16'h0, parent_irq}, 32'h0);
  endtask

  task automatic t_clear_all();
    logic [31:0] d;
    do_reset();
    // sources 2 and 3 -> line 0 core 0
    wr(8'h00, 32'h1111_0000, 4'b1100);
    wr(8'h28, 32'h0000_000C, 4'hF);
    irq_src[3:2] = 2'b11;
    idle(5);
    rd(8'h40, d); chk("R7 before clear", d, 32'h0000_000C);
    wr(8'h2C, 32'hFFFF_FFFF, 4'hF);
    rd(8'h40, d); chk("R7 status zero", d, 32'h0);
    idle(3);
    rd(8'h40, d); chk("R7 stays zero", d, 32'h0);
    chk("R7 parents zero", {16'h0, parent_irq}, 32'h0);
    wr(8'h28, 32'h0000_0004, 4'hF);
    rd(8'h40, d); chk("R7 re-enable", d, 32'h0000_0004);
  endtask

  task automatic t_fanout();
    logic [31:0] d;
    do_reset();
    // src20 byte 0x19: line0, cores 0 and 3 -> bits 0,12
    // src22 byte 0x84: line3, core 2 -> bit 11; src21 byte 0x00 -> nowhere
    wr(8'h14, 32'h0084_0019, 4'b0101);
    wr(8'h28, 32'h0070_0000, 4'hF);
    irq_src[22:20] = 3'b111;
    idle(6);
    chk("R8 fanout", {16'h0, parent_irq}, 32'h0000_1801);
    rd(8'h40, d); chk("R8 status of all", d, 32'h0070_0000);
    irq_src[20] = 1'b0; irq_src[22] = 1'b0;
    idle(6);
    chk("R8 route zero drives nothing", {16'h0, parent_irq}, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    do_reset();
    wr(8'h3C, 32'hFFFF_FFFF, 4'hF);
    wr(8'h20, 32'hFFFF_FFFF, 4'hF);
    wr(8'h44, 32'hFFFF_FFFF, 4'hF);
    wr(8'h29, 32'hFFFF_FFFF, 4'hF);
    wr(8'h35, 32'hFFFF_FFFF, 4'hF);
    rd(8'h24, d); chk("R10 enable untouched", d, 32'h0);
    rd(8'h30, d); chk("R10 polarity untouched", d, 32'hFFFF_FFFF);
    rd(8'h34, d); chk("R10 edge untouched", d, 32'h0);
    rd(8'h3C, d); chk("R10 read hole", d, 32'h0);
    wr(8'h30, 32'h0, 4'hF);
    rd(8'h32, d); chk("R10 unaligned read", d, 32'h0);
    rd(8'h44, d); chk("R10 read beyond", d, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_route();
    t_mask();
    t_level();
    t_edge();
    t_clear_all();
    t_fanout();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule